// File: doc/BRIEF.md
# Half-Duplex Serial Byte Master

This block is the controlling end of a three-wire-plus-select serial link that moves a single byte per transaction, either outward to a peripheral or inward from it. The transfer direction is chosen per transaction and is presented to the peripheral on a dedicated direction pin. Because of this, only one of the two data lines carries data at any time.

A one-cycle start request, accepted while the block is idle, captures the direction, the parallel write byte and a half-period count. The block then pulls the active-low select line down and toggles the serial clock each time a half-period timer expires. The timer counts ticks from a prescaler that divides the system clock to a 1 µs tick, so counts of 104 and 52 give roughly 4800 and 9600 bit/s. Data moves most significant bit first. The master samples the input line on rising clock edges and changes the output line on falling edges. When select returns high, a one-cycle completion pulse is raised and, for an inward transfer, the received byte appears on the parallel read output.

Top module: `hdspi_master`

## Requirements
- R1: While reset is asserted and right after it: cs_n=1, sck=0, sdo=0, sdir=0, done=0, rdata=0.
- R2: A start pulse seen while idle drives cs_n low at the next clock edge. The first sck edge follows P clocks later, where P = TICK_DIV × half_cnt, and a half_cnt of 0 counts as 1.
- R3: While cs_n is low, sck changes level every P clocks, 16 times in total, beginning with a rise. sck is low whenever cs_n is high.
- R4: With sdir=1 (outward), sdo carries wdata MSB first. The MSB is present from the clock edge where cs_n falls, and each later bit appears at a falling sck edge. sdo is 0 after the eighth falling edge.
- R5: With sdir=0 (inward), sdi is sampled at each rising sck edge, MSB first, and the byte is placed on rdata when cs_n rises. An outward transfer leaves rdata unchanged.
- R6: cs_n rises P clocks after the 16th sck edge, and done is high for exactly that one clock.
- R7: A start pulse is ignored while a transfer is in progress, including in the cycle where cs_n returns high. A start pulse in the very next cycle is accepted.
- R8: dir_wr, half_cnt and wdata are captured only when a start is accepted. sdir holds the captured direction (1 = master writes, 0 = master reads) until the next accepted start, and changes to those inputs while cs_n is low have no effect.
- R9: sdo stays 0 during an inward transfer and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transaction request |
| dir_wr | input | 1 | Requested direction: 1 write to slave, 0 read from slave |
| half_cnt | input | HALF_W | Half-period length in 1 µs ticks |
| wdata | input | DATA_W | Byte to send on an outward transfer |
| rdata | output | DATA_W | Byte received on the last inward transfer |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Active-low select |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sdir | output | 1 | Direction shown to the slave |

## Verification
Completion and a new request can land in the same cycle. The bench raises start in exactly the cycle where cs_n returns high and done pulses. That request must be dropped: cs_n must still be high one cycle later. A second request in the following cycle must then start a fresh transfer, and a cycle-by-cycle model judges it with no gap lost. The other collision is the sck rise that samples sdi in the cycle the bench-side slave might move the line. The slave moves sdi only after a falling edge, and the received byte is compared with what the slave sent.

// File: rtl/hdspi_pkg.sv
package hdspi_pkg;
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_e;
endpackage

// File: rtl/hdspi_prescale.sv
module hdspi_prescale #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_count
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_d, pre_q;

            always_comb begin
                if (!run)
                    pre_d = '0;
                else if (pre_q == LAST)
                    pre_d = '0;
                else
                    pre_d = pre_q + PW'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pre_q <= '0;
                else        pre_q <= pre_d;
            end

            assign tick = run && (pre_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/hdspi_halftimer.sv
module hdspi_halftimer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] tmr_d, tmr_q;
    logic          at_end;

    assign at_end = (tmr_q == limit - CW'(1));

    always_comb begin
        if (!run)
            tmr_d = '0;
        else if (tick)
            tmr_d = at_end ? '0 : tmr_q + CW'(1);
        else
            tmr_d = tmr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expire = run && tick && at_end;

    // R3: the count never passes the captured half-period limit
    assert_timer_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tmr_q < limit));
endmodule

// File: rtl/hdspi_master.sv
module hdspi_master
    import hdspi_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_W   = 8,
    parameter int TICK_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_wr,
    input  logic [HALF_W-1:0] half_cnt,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              cs_n,
    output logic              sck,
    output logic              sdo,
    input  logic              sdi,
    output logic              sdir
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES + 1);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES);

    typedef struct packed {
        logic              busy;
        dir_e              dir;
        logic              sck;
        logic              samp;
        logic              done;
        logic [EW-1:0]     edges;
        logic [HALF_W-1:0] limit;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rdata;
    } reg_t;

    reg_t r_d, r_q;
    logic tick, expire;

    hdspi_prescale #(.DIV(TICK_DIV)) i_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.busy),
        .tick  (tick)
    );

    hdspi_halftimer #(.CW(HALF_W)) i_halftimer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (r_q.busy),
        .tick   (tick),
        .limit  (r_q.limit),
        .expire (expire)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.busy) begin
            if (start) begin
                r_d.busy  = 1'b1;
                r_d.dir   = dir_e'(dir_wr);
                r_d.limit = (half_cnt == '0) ? HALF_W'(1) : half_cnt;
                r_d.sh    = wdata;
                r_d.samp  = 1'b0;
                r_d.sck   = 1'b0;
                r_d.edges = '0;
            end
        end else if (expire) begin
            if (r_q.edges == LAST_EDGE) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
                if (r_q.dir == DIR_READ)
                    r_d.rdata = r_q.sh;
            end else begin
                r_d.edges = r_q.edges + EW'(1);
                if (!r_q.sck) begin
                    r_d.sck = 1'b1;
                    if (r_q.dir == DIR_READ)
                        r_d.samp = sdi;
                end else begin
                    r_d.sck = 1'b0;
                    r_d.sh  = {r_q.sh[DATA_W-2:0], r_q.samp};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cs_n  = ~r_q.busy;
    assign sck   = r_q.sck;
    assign sdo   = r_q.busy && (r_q.dir == DIR_WRITE) && r_q.sh[DATA_W-1];
    assign sdir  = r_q.dir;
    assign rdata = r_q.rdata;
    assign done  = r_q.done;

    assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    assert_done_with_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));

    assert_sdir_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(sdir));

    assert_sdo_moves_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && !$fell(sck)) |-> $stable(sdo));

    assert_read_sdo_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !sdir) |-> !sdo);
endmodule

// File: tb/test_hdspi_master.sv
module test_hdspi_master;
    localparam int TDIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       dir_wr = 1'b0;
    logic [7:0] half_cnt = 8'd1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       done, cs_n, sck, sdo, sdir;
    logic       sdi = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    hdspi_master #(.DATA_W(8), .HALF_W(8), .TICK_DIV(TDIV)) i_hdspi_master (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
        .half_cnt(half_cnt), .wdata(wdata), .rdata(rdata), .done(done),
        .cs_n(cs_n), .sck(sck), .sdo(sdo), .sdi(sdi), .sdir(sdir)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // behavioural reference model
    logic       m_busy = 0, m_dir = 0, m_done = 0;
    int         m_n = 0, m_p = 1;
    logic [7:0] m_wd = 0, m_rd = 0, m_sb = 0;
    logic [7:0] slave_byte = 8'h00;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_dir = 0; m_done = 0; m_n = 0; m_rd = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_n++;
                if (m_n == 17 * m_p) begin
                    m_busy = 0;
                    m_done = 1;
                    if (!m_dir) m_rd = m_sb;
                end
            end else if (start) begin
                m_busy = 1; m_n = 0; m_dir = dir_wr; m_wd = wdata; m_sb = slave_byte;
                m_p = TDIV * ((half_cnt == 0) ? 1 : int'(half_cnt));
            end
        end
        if (cyc > 100000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // bench-side slave: moves sdi only after a falling sck
    logic sck_prev = 0;
    int   bitpos = 7;
    always @(negedge clk) begin
        if (cs_n) begin
            bitpos = 7;
        end else if (sck_prev && !sck && bitpos > 0) begin
            bitpos--;
        end
        sdi = slave_byte[bitpos];
        sck_prev = sck;
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            int k;
            logic e_sck, e_sdo;
            k = m_n / m_p;
            e_sck = m_busy && (k % 2 == 1);
            e_sdo = m_busy && m_dir && (k < 16) && m_wd[7 - k / 2];
            chk(cs_n == !m_busy, "R2/R6 cs_n", cs_n, !m_busy);
            chk(sck == e_sck, "R3 sck", sck, e_sck);
            chk(sdo == e_sdo, "R4/R9 sdo", sdo, e_sdo);
            chk(done == m_done, "R6 done", done, m_done);
            chk(sdir == m_dir, "R8 sdir", sdir, m_dir);
            chk(rdata == m_rd, "R5 rdata", rdata, m_rd);
        end
    end

    task automatic kick(input logic d, input logic [7:0] wd, input logic [7:0] hc,
                        input logic [7:0] sb);
        @(negedge clk);
        dir_wr = d; wdata = wd; half_cnt = hc; slave_byte = sb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_busy);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1 && sck == 0 && sdo == 0 && done == 0, "R1 pins in reset",
            {cs_n, sck, sdo, done}, 4'b1000);
        chk(sdir == 0 && rdata == 0, "R1 sdir/rdata in reset", {sdir, rdata}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        kick(1'b1, 8'hA5, 8'd3, 8'h00);          // R4 outward
        wait_idle();
        kick(1'b0, 8'h00, 8'd2, 8'h3C);          // R5 inward
        wait_idle();
        chk(rdata == 8'h3C, "R5 received byte", rdata, 8'h3C);
        kick(1'b1, 8'h80, 8'd0, 8'hFF);          // R2 zero count treated as one
        wait_idle();
        chk(rdata == 8'h3C, "R5 outward leaves rdata", rdata, 8'h3C);

        // R7/R8: noise on inputs and start while busy
        kick(1'b1, 8'h5A, 8'd2, 8'h00);
        repeat (7) @(negedge clk);
        dir_wr = 1'b0; half_cnt = 8'd5; wdata = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(m_busy && m_n == 17 * m_p - 1)) @(negedge clk);
        start = 1'b1;                              // lands on the release cycle
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == 1'b1, "R7 start on release ignored", cs_n, 1);
        dir_wr = 1'b0; half_cnt = 8'd1; slave_byte = 8'hC3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cs_n == 1'b0, "R7 next-cycle start accepted", cs_n, 0);
        wait_idle();
        chk(rdata == 8'hC3, "R5 back-to-back read", rdata, 8'hC3);

        kick(1'b0, 8'h00, 8'd1, 8'hFF);
        wait_idle();
        chk(rdata == 8'hFF, "R5 all ones", rdata, 8'hFF);
        kick(1'b0, 8'h00, 8'd4, 8'h01);
        wait_idle();
        chk(rdata == 8'h01, "R5 LSB only", rdata, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule